// File: doc/BRIEF.md
# Multi-Phase Fractional Pulse-Width Generator

This block turns a pulse width, counted in phase steps of an eight-phase clock, into one output pulse per switching period. Each phase is the base clock delayed by one eighth of its period, so one base clock cycle holds eight phase steps. The block splits the width into whole base-clock cycles and a leftover number of phases. For each whole cycle it enables every phase. In the single cycle that follows, it enables only the leftover phases. It then holds the output low until the period ends. A downstream cell ORs the enabled phase clocks to form the actual pulse edge, which gives a resolution eight times finer than the base clock.

The switching period is given in base clock cycles and is sampled at each period end. A value of zero stops the generator. A new width is captured on a load strobe into a pending register. It only reaches the output at the next period start, so a pulse already in progress is never cut short or stretched. A width of at least the full period in phase steps saturates to an output that stays high for the whole period.

Top module: `mpwm_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `phase_mask` is zero and `full_on` and `cycle_start` are low. The pending width is cleared to zero.
- R2: When `period_cfg` is zero at a period end, or while the generator is idle, the generator stops. From the next cycle on, all outputs stay zero and `cycle_start` stays low until a nonzero period is sampled.
- R3: While running, `cycle_start` is high in the first cycle of each period, exactly once per period. Its rising cycles are spaced by the period length that was sampled when that period began.
- R4: For an effective width E, the first E/8 cycles of a period (positions 0 to E/8-1) drive `phase_mask` = all ones with `full_on` high.
- R5: If E mod 8 = m is nonzero, the cycle at position E/8 drives `phase_mask` with bits 0 to m-1 set and the other bits clear, where bit i enables phase i. `full_on` is low in that cycle.
- R6: Every later position in the period drives `phase_mask` = 0 with `full_on` low.
- R7: A width of zero leaves the output low for the whole period.
- R8: A width at or above 8 times the period length saturates to E = 8 times the period, so the mask is all ones for every cycle of the period.
- R9: `width_load` captures `width_in` into a pending register. The pending value is applied only at the next period start, and the current period keeps its width. A load on the edge that ends a period reaches the period after next.
- R10: A change on `period_cfg` in the middle of a period has no effect until that period ends. The next period then takes the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| period_cfg | input | PER_W (8) | Switching period in base clock cycles; 0 stops the generator |
| width_in | input | PER_W+3 (11) | Requested pulse width in phase steps |
| width_load | input | 1 | Captures width_in into the pending register |
| phase_mask | output | 8 | Phase enables for the current cycle; bit i enables phase i |
| full_on | output | 1 | High in cycles where every phase is enabled |
| cycle_start | output | 1 | High in the first cycle of each switching period |

## Verification
The in-line assertions cover properties that hold on every cycle. The position counter stays inside the active period, and the period and width split do not move in mid-period. A zero period always stops the generator, and the phase mask is always a contiguous run from bit 0. A saturated width never carries a remainder. The exact mask at each position depends on the arithmetic split of a given width against a given period. That cannot be stated without a model, so only the bench can show it. The bench sweeps every width from zero past the saturation point over several period lengths, and it also checks mid-period loads, period changes and stopping.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int PHASES  = 8;
    localparam int PH_BITS = $clog2(PHASES);

    typedef logic [PHASES-1:0] phase_mask_t;

    typedef enum logic [1:0] {
        SEG_IDLE = 2'd0,
        SEG_FULL = 2'd1,
        SEG_FRAC = 2'd2
    } seg_e;

    // Mask with the lowest 'cnt' phase bits set.
    function automatic phase_mask_t low_phases(input logic [PH_BITS-1:0] cnt);
        phase_mask_t m;
        for (int i = 0; i < PHASES; i++) begin
            m[i] = (i < int'(cnt));
        end
        return m;
    endfunction

endpackage

// File: rtl/mpwm_period_timer.sv
module mpwm_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_cfg,
    output logic             run,
    output logic [PER_W-1:0] pos,
    output logic [PER_W-1:0] per,
    output logic             boundary
);

    // A boundary is the last cycle of a period, or any idle cycle.
    always_comb begin
        boundary = !run || (pos == per - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            pos <= '0;
            per <= '0;
        end else if (boundary) begin
            pos <= '0;
            if (period_cfg == '0) begin
                run <= 1'b0;
                per <= '0;
            end else begin
                run <= 1'b1;
                per <= period_cfg;
            end
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assert_pos_in_period_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos < per));

    assert_zero_period_stops_R2: assert property (@(posedge clk) disable iff (rst)
        (boundary && period_cfg == '0) |=> !run);

    assert_period_held_R10: assert property (@(posedge clk) disable iff (rst)
        (run && !boundary) |=> $stable(per));

endmodule

// File: rtl/mpwm_width_split.sv
module mpwm_width_split
    import mpwm_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int WID_W = PER_W + PH_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WID_W-1:0]   width_in,
    input  logic               width_load,
    input  logic               boundary,
    input  logic [PER_W-1:0]   period_cfg,
    output logic [PER_W-1:0]   whole_cnt,
    output logic [PH_BITS-1:0] frac_cnt
);

    logic [WID_W-1:0] pend;
    logic [WID_W-1:0] limit;
    logic             saturate;

    always_comb begin
        limit    = {period_cfg, {PH_BITS{1'b0}}};
        saturate = (pend >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (width_load) begin
            pend <= width_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            whole_cnt <= '0;
            frac_cnt  <= '0;
        end else if (boundary) begin
            if (saturate) begin
                whole_cnt <= period_cfg;
                frac_cnt  <= '0;
            end else begin
                whole_cnt <= pend[WID_W-1:PH_BITS];
                frac_cnt  <= pend[PH_BITS-1:0];
            end
        end
    end

    assert_split_held_R9: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> ($stable(whole_cnt) && $stable(frac_cnt)));

endmodule

// File: rtl/mpwm_phase_combiner.sv
module mpwm_phase_combiner
    import mpwm_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic               run,
    input  logic [PER_W-1:0]   pos,
    input  logic [PER_W-1:0]   whole_cnt,
    input  logic [PH_BITS-1:0] frac_cnt,
    output phase_mask_t        phase_mask,
    output logic               full_on,
    output logic               cycle_start
);

    seg_e seg;

    always_comb begin
        if (!run) begin
            seg = SEG_IDLE;
        end else if (pos < whole_cnt) begin
            seg = SEG_FULL;
        end else if (pos == whole_cnt && frac_cnt != '0) begin
            seg = SEG_FRAC;
        end else begin
            seg = SEG_IDLE;
        end
    end

    always_comb begin
        unique case (seg)
            SEG_FULL: phase_mask = '1;
            SEG_FRAC: phase_mask = low_phases(frac_cnt);
            default:  phase_mask = '0;
        endcase
        full_on     = (seg == SEG_FULL);
        cycle_start = run && (pos == '0);
    end

endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen
    import mpwm_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int WID_W = PER_W + PH_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PER_W-1:0]   period_cfg,
    input  logic [WID_W-1:0]   width_in,
    input  logic               width_load,
    output logic [PHASES-1:0]  phase_mask,
    output logic               full_on,
    output logic               cycle_start
);

    logic               run;
    logic               boundary;
    logic [PER_W-1:0]   pos;
    logic [PER_W-1:0]   per;
    logic [PER_W-1:0]   whole_cnt;
    logic [PH_BITS-1:0] frac_cnt;

    mpwm_period_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_cfg (period_cfg),
        .run        (run),
        .pos        (pos),
        .per        (per),
        .boundary   (boundary)
    );

    mpwm_width_split #(.PER_W(PER_W)) u_split (
        .clk        (clk),
        .rst        (rst),
        .width_in   (width_in),
        .width_load (width_load),
        .boundary   (boundary),
        .period_cfg (period_cfg),
        .whole_cnt  (whole_cnt),
        .frac_cnt   (frac_cnt)
    );

    mpwm_phase_combiner #(.PER_W(PER_W)) u_comb (
        .run         (run),
        .pos         (pos),
        .whole_cnt   (whole_cnt),
        .frac_cnt    (frac_cnt),
        .phase_mask  (phase_mask),
        .full_on     (full_on),
        .cycle_start (cycle_start)
    );

    assert_mask_contiguous_R5: assert property (@(posedge clk) disable iff (rst)
        ((phase_mask & (phase_mask + 1'b1)) == '0));

    assert_saturate_no_frac_R8: assert property (@(posedge clk) disable iff (rst)
        (run && whole_cnt >= per) |-> (frac_cnt == '0));

    assert_single_start_R3: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && per != 1) |=> !cycle_start);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !run |-> (phase_mask == '0 && !cycle_start));

endmodule

// File: tb/mpwm_gen_bench.sv
`timescale 1ns/1ps
module mpwm_gen_bench;

    localparam int PER_W = 8;
    localparam int WID_W = PER_W + 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PER_W-1:0] period_cfg = '0;
    logic [WID_W-1:0] width_in = '0;
    logic             width_load = 1'b0;
    logic [7:0]       phase_mask;
    logic             full_on;
    logic             cycle_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mpwm_gen #(.PER_W(PER_W)) u_mpwm_gen (
        .clk         (clk),
        .rst         (rst),
        .period_cfg  (period_cfg),
        .width_in    (width_in),
        .width_load  (width_load),
        .phase_mask  (phase_mask),
        .full_on     (full_on),
        .cycle_start (cycle_start)
    );

    function automatic logic [7:0] exp_mask(int w, int p, int k);
        int e;
        int q;
        int m;
        e = (w >= 8 * p) ? 8 * p : w;
        q = e / 8;
        m = e % 8;
        if (k < q) return 8'hFF;
        if (k == q && m != 0) return 8'((1 << m) - 1);
        return 8'h00;
    endfunction

    function automatic string mask_tag(int w, int p, int k);
        int q;
        if (w == 0) return "R7";
        if (w >= 8 * p) return "R8";
        q = w / 8;
        if (k < q) return "R4";
        if (k == q) return "R5";
        return "R6";
    endfunction

    task automatic check_out(string tag, logic [7:0] em, logic es);
        checks++;
        if (phase_mask !== em || full_on !== (em == 8'hFF) || cycle_start !== es) begin
            errors++;
            $display("FAIL %s: mask=%h full=%b start=%b expected mask=%h full=%b start=%b",
                     tag, phase_mask, full_on, cycle_start, em, (em == 8'hFF), es);
        end
    endtask

    task automatic run_case(int p, int w, int p2, int w2_req);
        int w2;
        w2 = (p >= 2) ? w2_req : w;
        @(negedge clk);
        rst = 1'b1; width_load = 1'b0; period_cfg = '0;
        @(negedge clk);
        check_out("R1", 8'h00, 1'b0);
        rst = 1'b0; width_in = WID_W'(w); width_load = 1'b1;
        @(negedge clk);
        check_out("R2", 8'h00, 1'b0);
        width_load = 1'b0; period_cfg = PER_W'(p);
        for (int k = 0; k < p + p2; k++) begin
            @(negedge clk);
            if (k < p) begin
                check_out(mask_tag(w, p, k), exp_mask(w, p, k), k == 0);
            end else begin
                // second period: new width (R9) and new length (R10)
                check_out((k == p) ? "R10" : "R9", exp_mask(w2, p2, k - p), k == p);
                if (!(exp_mask(w2, p2, k - p) === phase_mask)) begin
                    $display("  detail R9: case p=%0d w=%0d p2=%0d w2=%0d pos=%0d", p, w, p2, w2, k - p);
                end
            end
            width_load = 1'b0;
            if (k == 0) begin
                period_cfg = PER_W'(p2);
                if (p >= 2) begin
                    width_in = WID_W'(w2);
                    width_load = 1'b1;
                end
            end
            if (k == p) period_cfg = '0;
        end
        @(negedge clk);
        check_out("R2", 8'h00, 1'b0);
        @(negedge clk);
        check_out("R2", 8'h00, 1'b0);
    endtask

    initial begin
        int plist [4] = '{1, 2, 3, 5};
        repeat (3) @(negedge clk);
        check_out("R1", 8'h00, 1'b0);
        foreach (plist[i]) begin
            for (int w = 0; w <= 8 * plist[i] + 4; w++) begin
                int p2;
                p2 = (plist[i] % 3) + 1;
                run_case(plist[i], w, p2, (w * 3 + 5) % (8 * p2 + 3));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule